// File: doc/BRIEF.md
# Result Retirement Distance Router

This block sits where execution units retire their results. Each result arrives with a destination tag and a two-bit reuse-distance hint from the compiler, and the router steers it by that hint. A result wanted on the very next cycle goes out on a registered forward port to the consuming unit. A result wanted a few cycles later goes into a small tagged short-delay buffer. A result wanted much later goes into a larger tagged long-delay buffer. A result with no reuse hint skips both buffers and goes to a one-entry bypass stage that writes toward the level-1 data store. That stage holds its result while the store side is busy.

Consumers fetch buffered results through a tag lookup port. The lookup searches the short buffer before the long buffer, and a hit releases the matching entry. When the buffer a result is aimed at has no free slot, the result goes to the bypass path instead and a saturating demotion counter steps up. The router takes at most one result per cycle under a valid/ready handshake. It drops ready only while the bypass stage is occupied and its downstream is not ready.

Top module: `result_router`

## Requirements
- R1: After reset, in_ready_o is 1, fwd_valid_o and byp_valid_o are 0, demote_cnt_o is 0, and both buffers are empty, so every lookup misses.
- R2: A result is accepted on a rising edge where in_valid_i and in_ready_o are both 1. Hint code 2'b01 (immediate) makes fwd_valid_o 1 for exactly the next cycle, with fwd_data_o and fwd_tag_o equal to the accepted result. The result is not buffered and does not go to the bypass port.
- R3: An accepted result with hint code 2'b10 (short) is written into the 4-entry short buffer when that buffer has a free slot. It produces no forward or bypass output.
- R4: An accepted result with hint code 2'b11 (long) is written into the 16-entry long buffer when that buffer has a free slot. It produces no forward or bypass output.
- R5: An accepted result with hint code 2'b00 (none) appears on the bypass port in the next cycle, with byp_valid_o set to 1 and the result's data and tag. It is never forwarded and never buffered.
- R6: While byp_valid_o is 1 and byp_ready_i is 0, byp_valid_o, byp_data_o and byp_tag_o hold their values into the next cycle.
- R7: in_ready_o is 0 exactly when byp_valid_o is 1 and byp_ready_i is 0. A result offered while ready is 0 is not taken.
- R8: With lkp_valid_i at 1, lkp_hit_o and lkp_data_o respond in the same cycle. The short buffer is searched first, then the long buffer. The matching entry is released at the next rising edge. With lkp_valid_i at 0, lkp_hit_o is 0 and nothing is released.
- R9: A short-hint or long-hint result aimed at a full buffer goes to the bypass port in the next cycle, as in R5. demote_cnt_o then increases by one, saturating at its maximum, and never decreases except through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Result offered |
| in_ready_o | output | 1 | Router can take a result |
| in_data_i | input | DATA_W | Result value |
| in_tag_i | input | TAG_W | Destination tag |
| in_hint_i | input | 2 | Reuse hint: 00 none, 01 immediate, 10 short, 11 long |
| fwd_valid_o | output | 1 | Forwarded result valid (one cycle) |
| fwd_data_o | output | DATA_W | Forwarded value |
| fwd_tag_o | output | TAG_W | Forwarded tag |
| byp_valid_o | output | 1 | Bypass write pending |
| byp_ready_i | input | 1 | Level-1 store side accepts bypass write |
| byp_data_o | output | DATA_W | Bypass value |
| byp_tag_o | output | TAG_W | Bypass tag |
| lkp_valid_i | input | 1 | Consumer lookup request |
| lkp_tag_i | input | TAG_W | Tag looked up |
| lkp_hit_o | output | 1 | Lookup found a buffered result |
| lkp_data_o | output | DATA_W | Value found |
| demote_cnt_o | output | CNT_W | Saturating count of demotions to bypass |

## Verification
A corrupted valid bit in either buffer shows up at the lookup port. A freed entry still hits, a live entry misses, or a full-buffer condition arrives early or late, which shows one cycle after the write as an unexpected bypass output and a counter step. A stale bypass holding register shows as in_ready_o held low or as byp_data_o changing during a stall within one cycle. Wrong search order between the buffers shows as the long-buffer value returned for a tag present in both buffers.

// File: rtl/router_pkg.sv
package router_pkg;
  typedef enum logic [1:0] {
    HINT_NONE  = 2'b00,
    HINT_IMM   = 2'b01,
    HINT_SHORT = 2'b10,
    HINT_LONG  = 2'b11
  } hint_e;
endpackage

// File: rtl/router_tag_buf.sv
module router_tag_buf #(
  parameter int DEPTH  = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              full_o,
  input  logic              take_i,
  input  logic [TAG_W-1:0]  lkp_tag_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] hit_data_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  vld_q;
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [IDX_W-1:0]  free_idx, hit_idx;
  logic              hit;

  // lowest free slot and lowest matching slot
  always_comb begin
    free_idx = '0;
    hit_idx  = '0;
    hit      = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld_q[i]) free_idx = IDX_W'(i);
      if (vld_q[i] && tag_q[i] == lkp_tag_i) begin
        hit_idx = IDX_W'(i);
        hit     = 1'b1;
      end
    end
  end

  assign full_o     = &vld_q;
  assign hit_o      = hit;
  assign hit_data_o = data_q[hit_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (take_i && hit && hit_idx == IDX_W'(i)) vld_q[i] <= 1'b0;
        if (wr_en_i && !full_o && free_idx == IDX_W'(i)) begin
          vld_q[i]  <= 1'b1;
          tag_q[i]  <= wr_tag_i;
          data_q[i] <= wr_data_i;
        end
      end
    end
  end
endmodule

// File: rtl/router_bypass_stage.sv
module router_bypass_stage #(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              can_load_o,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [TAG_W-1:0]  tag_o,
  output logic [DATA_W-1:0] data_o
);
  logic              vld_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] data_q;

  assign can_load_o = !vld_q || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      tag_q  <= '0;
      data_q <= '0;
    end else if (load_i && can_load_o) begin
      vld_q  <= 1'b1;
      tag_q  <= tag_i;
      data_q <= data_i;
    end else if (ready_i) begin
      vld_q <= 1'b0;
    end
  end

  assign valid_o = vld_q;
  assign tag_o   = tag_q;
  assign data_o  = data_q;
endmodule

// File: rtl/router_sat_counter.sv
module router_sat_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (inc_i && !(&cnt_q)) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/result_router.sv
module result_router
  import router_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int TAG_W   = 6,
  parameter int S_DEPTH = 4,
  parameter int L_DEPTH = 16,
  parameter int CNT_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic [TAG_W-1:0]  in_tag_i,
  input  logic [1:0]        in_hint_i,
  output logic              fwd_valid_o,
  output logic [DATA_W-1:0] fwd_data_o,
  output logic [TAG_W-1:0]  fwd_tag_o,
  output logic              byp_valid_o,
  input  logic              byp_ready_i,
  output logic [DATA_W-1:0] byp_data_o,
  output logic [TAG_W-1:0]  byp_tag_o,
  input  logic              lkp_valid_i,
  input  logic [TAG_W-1:0]  lkp_tag_i,
  output logic              lkp_hit_o,
  output logic [DATA_W-1:0] lkp_data_o,
  output logic [CNT_W-1:0]  demote_cnt_o
);
  hint_e             hint;
  logic              acc, byp_can_load;
  logic              s_full, l_full, s_hit, l_hit;
  logic [DATA_W-1:0] s_data, l_data;
  logic              s_wr, l_wr, demote, byp_load;
  logic              fwd_vld_q;
  logic [DATA_W-1:0] fwd_data_q;
  logic [TAG_W-1:0]  fwd_tag_q;

  assign hint       = hint_e'(in_hint_i);
  assign in_ready_o = byp_can_load;
  assign acc        = in_valid_i && in_ready_o;

  assign s_wr     = acc && hint == HINT_SHORT && !s_full;
  assign l_wr     = acc && hint == HINT_LONG  && !l_full;
  assign demote   = acc && ((hint == HINT_SHORT && s_full) ||
                            (hint == HINT_LONG  && l_full));
  assign byp_load = (acc && hint == HINT_NONE) || demote;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_vld_q  <= 1'b0;
      fwd_data_q <= '0;
      fwd_tag_q  <= '0;
    end else begin
      fwd_vld_q <= acc && hint == HINT_IMM;
      if (acc && hint == HINT_IMM) begin
        fwd_data_q <= in_data_i;
        fwd_tag_q  <= in_tag_i;
      end
    end
  end

  assign fwd_valid_o = fwd_vld_q;
  assign fwd_data_o  = fwd_data_q;
  assign fwd_tag_o   = fwd_tag_q;

  router_tag_buf #(.DEPTH(S_DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_sbuf (
    .clk_i, .rst_ni,
    .wr_en_i    (s_wr),
    .wr_tag_i   (in_tag_i),
    .wr_data_i  (in_data_i),
    .full_o     (s_full),
    .take_i     (lkp_valid_i),
    .lkp_tag_i  (lkp_tag_i),
    .hit_o      (s_hit),
    .hit_data_o (s_data)
  );

  // long buffer only releases when the short buffer missed
  router_tag_buf #(.DEPTH(L_DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lbuf (
    .clk_i, .rst_ni,
    .wr_en_i    (l_wr),
    .wr_tag_i   (in_tag_i),
    .wr_data_i  (in_data_i),
    .full_o     (l_full),
    .take_i     (lkp_valid_i && !s_hit),
    .lkp_tag_i  (lkp_tag_i),
    .hit_o      (l_hit),
    .hit_data_o (l_data)
  );

  assign lkp_hit_o  = lkp_valid_i && (s_hit || l_hit);
  assign lkp_data_o = s_hit ? s_data : l_data;

  router_bypass_stage #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_byp (
    .clk_i, .rst_ni,
    .load_i     (byp_load),
    .tag_i      (in_tag_i),
    .data_i     (in_data_i),
    .can_load_o (byp_can_load),
    .valid_o    (byp_valid_o),
    .ready_i    (byp_ready_i),
    .tag_o      (byp_tag_o),
    .data_o     (byp_data_o)
  );

  router_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .inc_i (demote),
    .cnt_o (demote_cnt_o)
  );
endmodule

// File: rtl/result_router_checker.sv
module result_router_checker #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 6,
  parameter int CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [DATA_W-1:0] in_data_i,
  input logic [TAG_W-1:0]  in_tag_i,
  input logic [1:0]        in_hint_i,
  input logic              fwd_valid_o,
  input logic [DATA_W-1:0] fwd_data_o,
  input logic [TAG_W-1:0]  fwd_tag_o,
  input logic              byp_valid_o,
  input logic              byp_ready_i,
  input logic [DATA_W-1:0] byp_data_o,
  input logic [TAG_W-1:0]  byp_tag_o,
  input logic              lkp_valid_i,
  input logic [TAG_W-1:0]  lkp_tag_i,
  input logic              lkp_hit_o,
  input logic [DATA_W-1:0] lkp_data_o,
  input logic [CNT_W-1:0]  demote_cnt_o
);
  AST_FWD_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && in_hint_i == 2'b01) |=>
      (fwd_valid_o && fwd_data_o == $past(in_data_i) && fwd_tag_o == $past(in_tag_i))); // R2

  AST_FWD_ONLY_IMM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && in_ready_o && in_hint_i == 2'b01) |=> !fwd_valid_o); // R2

  AST_NONE_TO_BYP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && in_hint_i == 2'b00) |=>
      (byp_valid_o && byp_data_o == $past(in_data_i) && byp_tag_o == $past(in_tag_i))); // R5

  AST_BYP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byp_valid_o && !byp_ready_i) |=>
      (byp_valid_o && $stable(byp_data_o) && $stable(byp_tag_o))); // R6

  AST_READY_RULE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |-> (byp_valid_o && !byp_ready_i)); // R7

  AST_HIT_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_hit_o |-> lkp_valid_i); // R8

  AST_CNT_NO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    demote_cnt_o >= $past(demote_cnt_o)); // R9
endmodule

bind result_router result_router_checker #(
  .DATA_W(DATA_W), .TAG_W(TAG_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/result_router_bench.sv
module result_router_bench;
  localparam int DATA_W = 32;
  localparam int TAG_W  = 6;
  localparam int CNT_W  = 8;
  localparam int NVEC   = 14;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [DATA_W-1:0] in_data = '0;
  logic [TAG_W-1:0]  in_tag = '0;
  logic [1:0]        in_hint = '0;
  logic              fwd_valid;
  logic [DATA_W-1:0] fwd_data;
  logic [TAG_W-1:0]  fwd_tag;
  logic              byp_valid;
  logic              byp_ready = 1'b1;
  logic [DATA_W-1:0] byp_data;
  logic [TAG_W-1:0]  byp_tag;
  logic              lkp_valid = 1'b0;
  logic [TAG_W-1:0]  lkp_tag = '0;
  logic              lkp_hit;
  logic [DATA_W-1:0] lkp_data;
  logic [CNT_W-1:0]  demote_cnt;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  result_router u_result_router (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .in_tag_i(in_tag), .in_hint_i(in_hint),
    .fwd_valid_o(fwd_valid), .fwd_data_o(fwd_data), .fwd_tag_o(fwd_tag),
    .byp_valid_o(byp_valid), .byp_ready_i(byp_ready),
    .byp_data_o(byp_data), .byp_tag_o(byp_tag),
    .lkp_valid_i(lkp_valid), .lkp_tag_i(lkp_tag),
    .lkp_hit_o(lkp_hit), .lkp_data_o(lkp_data),
    .demote_cnt_o(demote_cnt)
  );

  // {lookup, hint[1:0], tag[5:0], data[31:0], exp_fwd, exp_byp, exp_hit}
  localparam logic [43:0] VEC [NVEC] = '{
    {1'b0, 2'b01, 6'd1, 32'h0000_00A1, 3'b100},
    {1'b0, 2'b00, 6'd2, 32'h0000_00B2, 3'b010},
    {1'b0, 2'b10, 6'd3, 32'h0000_00C3, 3'b000},
    {1'b0, 2'b11, 6'd4, 32'h0000_00D4, 3'b000},
    {1'b1, 2'b00, 6'd3, 32'h0000_00C3, 3'b001},
    {1'b1, 2'b00, 6'd3, 32'h0000_0000, 3'b000},
    {1'b1, 2'b00, 6'd4, 32'h0000_00D4, 3'b001},
    {1'b0, 2'b10, 6'd5, 32'h0000_00E5, 3'b000},
    {1'b0, 2'b11, 6'd5, 32'h0000_00F5, 3'b000},
    {1'b1, 2'b00, 6'd5, 32'h0000_00E5, 3'b001},
    {1'b1, 2'b00, 6'd5, 32'h0000_00F5, 3'b001},
    {1'b1, 2'b00, 6'd5, 32'h0000_0000, 3'b000},
    {1'b1, 2'b00, 6'd2, 32'h0000_0000, 3'b000},
    {1'b1, 2'b00, 6'd1, 32'h0000_0000, 3'b000}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, accept at posedge, leave at following negedge
  task automatic send(input logic [1:0] h, input logic [TAG_W-1:0] t,
                      input logic [DATA_W-1:0] d);
    in_valid = 1'b1; in_hint = h; in_tag = t; in_data = d;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic look(input logic [TAG_W-1:0] t, output logic h,
                      output logic [DATA_W-1:0] d);
    lkp_valid = 1'b1; lkp_tag = t;
    #1;
    h = lkp_hit; d = lkp_data;
    @(posedge clk); @(negedge clk);
    lkp_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic h;
    logic [DATA_W-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(in_ready == 1'b1, "R1 ready", in_ready, 1);
    chk(fwd_valid == 1'b0, "R1 fwd", fwd_valid, 0);
    chk(byp_valid == 1'b0, "R1 byp", byp_valid, 0);
    chk(demote_cnt == '0, "R1 cnt", demote_cnt, 0);
    look(6'd0, h, d);
    chk(h == 1'b0, "R1 empty lookup", h, 0);

    // table walk: R2 R3 R4 R5 R8
    for (int i = 0; i < NVEC; i++) begin
      logic [43:0] v;
      v = VEC[i];
      if (v[43]) begin
        look(v[40:35], h, d);
        chk(h == v[0], "R8 lookup hit", h, v[0]);
        if (v[0]) chk(d == v[34:3], "R8 lookup data (R3 R4 short first)", d, v[34:3]);
      end else begin
        send(v[42:41], v[40:35], v[34:3]);
        chk(fwd_valid == v[2], "R2 fwd valid", fwd_valid, v[2]);
        if (v[2]) chk(fwd_data == v[34:3] && fwd_tag == v[40:35], "R2 fwd data",
                      fwd_data, v[34:3]);
        chk(byp_valid == v[1], "R5 byp valid", byp_valid, v[1]);
        if (v[1]) chk(byp_data == v[34:3] && byp_tag == v[40:35], "R5 byp data",
                      byp_data, v[34:3]);
      end
    end

    // R2 forward lasts one cycle
    send(2'b01, 6'd7, 32'h77);
    @(negedge clk);
    chk(fwd_valid == 1'b0, "R2 single cycle", fwd_valid, 0);

    // R8 lookup disabled: no hit, no release
    send(2'b10, 6'd8, 32'h88);
    lkp_valid = 1'b0; lkp_tag = 6'd8;
    #1;
    chk(lkp_hit == 1'b0, "R8 idle lookup", lkp_hit, 0);
    @(posedge clk); @(negedge clk);
    look(6'd8, h, d);
    chk(h == 1'b1 && d == 32'h88, "R8 entry kept", d, 32'h88);

    // R9 short buffer full -> demote
    for (int i = 0; i < 4; i++) send(2'b10, 6'(10 + i), 32'h100 + i);
    chk(byp_valid == 1'b0, "R3 fill no byp", byp_valid, 0);
    send(2'b10, 6'd14, 32'h1E);
    chk(byp_valid == 1'b1 && byp_tag == 6'd14, "R9 short demote", byp_tag, 14);
    chk(demote_cnt == 8'd1, "R9 cnt 1", demote_cnt, 1);
    look(6'd14, h, d);
    chk(h == 1'b0, "R9 demoted not buffered", h, 0);
    for (int i = 0; i < 4; i++) begin
      look(6'(10 + i), h, d);
      chk(h == 1'b1 && d == 32'h100 + i, "R3 short entry", d, 32'h100 + i);
    end

    // R9 long buffer full -> demote
    for (int i = 0; i < 16; i++) send(2'b11, 6'(20 + i), 32'h200 + i);
    chk(demote_cnt == 8'd1, "R4 fill no demote", demote_cnt, 1);
    send(2'b11, 6'd40, 32'h2F);
    chk(byp_valid == 1'b1 && byp_data == 32'h2F, "R9 long demote", byp_data, 32'h2F);
    chk(demote_cnt == 8'd2, "R9 cnt 2", demote_cnt, 2);
    look(6'd35, h, d);
    chk(h == 1'b1 && d == 32'h20F, "R4 last long entry", d, 32'h20F);

    // R6 R7 bypass stall
    byp_ready = 1'b0;
    send(2'b00, 6'd50, 32'h55);
    chk(byp_valid == 1'b1 && byp_data == 32'h55, "R5 stall load", byp_data, 32'h55);
    chk(in_ready == 1'b0, "R7 ready low", in_ready, 0);
    in_valid = 1'b1; in_hint = 2'b01; in_tag = 6'd51; in_data = 32'h66;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    chk(byp_valid == 1'b1 && byp_data == 32'h55 && byp_tag == 6'd50, "R6 held",
        byp_data, 32'h55);
    chk(fwd_valid == 1'b0, "R7 not taken", fwd_valid, 0);
    byp_ready = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R7 ready back", in_ready, 1);
    @(posedge clk); @(negedge clk);
    chk(byp_valid == 1'b0, "R6 drained", byp_valid, 0);
    chk(fwd_valid == 1'b0, "R7 offer dropped", fwd_valid, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule